// File: doc/BRIEF.md
# Sparse Row-Wise Matrix Engine

This block multiplies a structured-sparse matrix A by a dense matrix B and returns the product one output row at a time. The columns of A are split into aligned windows of WIN_M entries, and each window keeps at most N_PORTS non-zero values. Each kept value carries its column offset inside the window. A tile of B, with one row per column of A, is written into a local buffer. The buffer has a single write port and N_PORTS independent read ports.

A is streamed in beats. Each beat carries N_PORTS (value, offset) pairs. Each pair's offset, combined with the current window number, addresses one read port. The B row returned by that port goes into a dedicated row of multipliers. The N_PORTS scaled rows are added together and then added into the accumulator for the output row, so the product is formed row by row, products first, with no systolic forwarding.

For windows holding more non-zeros than N_PORTS, a pass-count setting P spreads one window over P consecutive beats. All P beats read from the same window, and their products are summed.

The A stream and the result stream both use valid/ready. A beat or a B row moves only in a cycle where its valid and ready are both high. The result stays stable while y_valid is high and y_ready is low. During that time the engine takes no more A beats, so back-pressure on the result stalls the A stream. The B write port accepts rows only while no A row is open.

Top module: `srm_engine`

## Requirements
- R1: After reset, y_valid is 0, a_ready is 1 and b_ready is 1.
- R2: When b_valid and b_ready are both high, b_data is written into buffer row b_addr. b_ready is 0 from the cycle after an accepted beat that has a_first=1 and a_last=0, until the cycle after the beat with a_last=1 is accepted.
- R3: For each accepted beat, entry i contributes its signed value a_val[i*8+:8] times each lane of the B row it addresses. All N_PORTS entries of the beat are applied in the same cycle. Each result lane y_data[c*32+:32] is the sum of these contributions over the row's beats.
- R4: An entry whose value is zero contributes nothing, whatever its offset. A beat whose values are all zero leaves the accumulated row unchanged.
- R5: A beat with a_first=1 discards whatever was accumulated before it. A beat with both a_first and a_last set forms a complete one-beat row.
- R6: y_valid goes high in the cycle after the beat with a_last=1 is accepted. While y_valid is high and y_ready is low, y_valid stays high and y_data does not change.
- R7: a_ready is low exactly when y_valid is high and y_ready is low.
- R8: pass_cfg is sampled on each accepted beat with a_first=1. A value of 0 counts as 1 and values above 4 count as 4. The window number advances after every P accepted beats of the row, so the P beats of a window all address that same window.
- R9: Operands are signed two's complement numbers of 8 bits, and products are sign-extended into signed 32-bit accumulators.
- R10: The buffer row an entry addresses is window*16 + offset. The offset is the 4-bit field a_idx[i*4+:4]. The window number starts at 0 on the a_first beat and wraps from WINDOWS-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pass_cfg | input | 3 | Beats per window in dense mode; sampled on the first beat of a row |
| b_valid | input | 1 | B row write request |
| b_ready | output | 1 | Buffer can be written (no A row open) |
| b_addr | input | 5 | Buffer row to write |
| b_data | input | 64 | B row, 8 signed 8-bit lanes |
| a_valid | input | 1 | A beat present |
| a_ready | output | 1 | Engine takes the A beat |
| a_first | input | 1 | Beat starts a new output row |
| a_last | input | 1 | Beat ends the output row |
| a_val | input | 32 | N_PORTS signed 8-bit values |
| a_idx | input | 16 | N_PORTS 4-bit window offsets |
| y_valid | output | 1 | Result row present |
| y_ready | input | 1 | Consumer takes the result row |
| y_data | output | 256 | Result row, 8 signed 32-bit lanes |

## Verification
A window counter that advances at the wrong beat, or a pass count that is clamped wrongly, shows up as a wrong y_data lane on the very next row, because every later product then reads the wrong B row. An accumulator that fails to clear corrupts the first result after the row that follows it. A wrong open-row or output-valid flag shows up within one cycle as a mismatch on b_ready, a_ready or y_valid. The reference model predicts these three flags on every clock, so such a fault is caught in the cycle it occurs.

// File: rtl/srm_pkg.sv
package srm_pkg;

  typedef enum logic {
    ROW_IDLE = 1'b0,
    ROW_OPEN = 1'b1
  } row_state_e;

  // Maps a raw pass setting onto the legal range 1..maxp.
  function automatic logic [7:0] clamp_passes(input logic [7:0] cfg, input logic [7:0] maxp);
    if (cfg == 8'd0) return 8'd1;
    if (cfg > maxp) return maxp;
    return cfg;
  endfunction

endpackage

// File: rtl/srm_bbuf.sv
module srm_bbuf #(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 64,
  parameter int RPORTS = 4,
  parameter int AWD    = 5
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [AWD-1:0]          wr_addr,
  input  logic [WIDTH-1:0]        wr_data,
  input  logic [RPORTS*AWD-1:0]   rd_addr,
  output logic [RPORTS*WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // One independent asynchronous read port per permitted non-zero.
  for (genvar p = 0; p < RPORTS; p++) begin : g_rport
    assign rd_data[p*WIDTH +: WIDTH] = mem[rd_addr[p*AWD +: AWD]];
  end

endmodule

// File: rtl/srm_lane.sv
module srm_lane #(
  parameter int COLS = 8,
  parameter int DW   = 8,
  parameter int ACCW = 32
) (
  input  logic [DW-1:0]        a_val,
  input  logic [COLS*DW-1:0]   brow,
  output logic [COLS*ACCW-1:0] prod
);

  localparam int PW2 = 2 * DW;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic signed [PW2-1:0] p;
    assign p = $signed(a_val) * $signed(brow[c*DW +: DW]);
    assign prod[c*ACCW +: ACCW] = ACCW'(p);
  end

endmodule

// File: rtl/srm_ctrl.sv
module srm_ctrl
  import srm_pkg::*;
#(
  parameter int WINDOWS = 2,
  parameter int WW      = 1,
  parameter int MAXP    = 4,
  parameter int PW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pass_cfg,
  input  logic          a_valid,
  input  logic          a_first,
  input  logic          a_last,
  input  logic          y_valid,
  input  logic          y_ready,
  output logic          a_ready,
  output logic          a_fire,
  output logic          b_ready,
  output logic          clr,
  output logic [WW-1:0] win,
  output logic          load_out
);

  row_state_e    st_q;
  logic [WW-1:0] win_q;
  logic [PW-1:0] pass_q, passes_q;
  logic [PW-1:0] p_eff, p_lim;

  assign a_ready  = !(y_valid && !y_ready);
  assign a_fire   = a_valid && a_ready;
  assign b_ready  = (st_q == ROW_IDLE);
  assign clr      = a_first;
  assign load_out = a_fire && a_last;

  always_comb begin
    p_lim = PW'(clamp_passes(8'(pass_cfg), 8'(MAXP)));
    if (a_first) begin
      win   = '0;
      p_eff = '0;
    end else begin
      win   = win_q;
      p_eff = pass_q;
      p_lim = passes_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ROW_IDLE;
      win_q    <= '0;
      pass_q   <= '0;
      passes_q <= PW'(1);
    end else if (a_fire) begin
      st_q     <= a_last ? ROW_IDLE : ROW_OPEN;
      passes_q <= p_lim;
      if (p_eff == p_lim - PW'(1)) begin
        pass_q <= '0;
        win_q  <= (win == WW'(WINDOWS - 1)) ? '0 : win + WW'(1);
      end else begin
        pass_q <= p_eff + PW'(1);
        win_q  <= win;
      end
    end
  end

endmodule

// File: rtl/srm_engine.sv
module srm_engine
  import srm_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int WIN_M   = 16,
  parameter int WINDOWS = 2,
  parameter int COLS    = 8,
  parameter int DW      = 8,
  parameter int ACCW    = 32,
  parameter int MAXP    = 4,
  localparam int IW     = $clog2(WIN_M),
  localparam int WW     = (WINDOWS > 1) ? $clog2(WINDOWS) : 1,
  localparam int AWD    = IW + ((WINDOWS > 1) ? $clog2(WINDOWS) : 0),
  localparam int DEPTH  = WINDOWS * WIN_M,
  localparam int PW     = $clog2(MAXP + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PW-1:0]           pass_cfg,
  input  logic                    b_valid,
  output logic                    b_ready,
  input  logic [AWD-1:0]          b_addr,
  input  logic [COLS*DW-1:0]      b_data,
  input  logic                    a_valid,
  output logic                    a_ready,
  input  logic                    a_first,
  input  logic                    a_last,
  input  logic [N_PORTS*DW-1:0]   a_val,
  input  logic [N_PORTS*IW-1:0]   a_idx,
  output logic                    y_valid,
  input  logic                    y_ready,
  output logic [COLS*ACCW-1:0]    y_data
);

  localparam int RW = COLS * DW;
  localparam int YW = COLS * ACCW;

  logic             a_fire, clr, load_out;
  logic [WW-1:0]    win;
  logic [N_PORTS*AWD-1:0] rd_addr;
  logic [N_PORTS*RW-1:0]  rd_data;
  logic [N_PORTS*YW-1:0]  prods;
  logic [YW-1:0]    acc_q, acc_d, y_q;
  logic             y_valid_q;

  srm_ctrl #(
    .WINDOWS(WINDOWS), .WW(WW), .MAXP(MAXP), .PW(PW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pass_cfg(pass_cfg),
    .a_valid(a_valid), .a_first(a_first), .a_last(a_last),
    .y_valid(y_valid_q), .y_ready(y_ready),
    .a_ready(a_ready), .a_fire(a_fire), .b_ready(b_ready),
    .clr(clr), .win(win), .load_out(load_out)
  );

  srm_bbuf #(
    .DEPTH(DEPTH), .WIDTH(RW), .RPORTS(N_PORTS), .AWD(AWD)
  ) u_bbuf (
    .clk(clk), .wr_en(b_valid && b_ready), .wr_addr(b_addr), .wr_data(b_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    if (WINDOWS > 1) begin : g_win
      assign rd_addr[p*AWD +: AWD] = {win, a_idx[p*IW +: IW]};
    end else begin : g_flat
      assign rd_addr[p*AWD +: AWD] = a_idx[p*IW +: IW];
    end
    srm_lane #(.COLS(COLS), .DW(DW), .ACCW(ACCW)) u_lane (
      .a_val(a_val[p*DW +: DW]),
      .brow(rd_data[p*RW +: RW]),
      .prod(prods[p*YW +: YW])
    );
  end

  // Column-wise reduction of the scaled rows into the accumulator.
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      logic [ACCW-1:0] s;
      s = clr ? '0 : acc_q[c*ACCW +: ACCW];
      for (int p = 0; p < N_PORTS; p++) s = s + prods[p*YW + c*ACCW +: ACCW];
      acc_d[c*ACCW +: ACCW] = s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      y_q       <= '0;
      y_valid_q <= 1'b0;
    end else begin
      if (a_fire) acc_q <= acc_d;
      if (load_out) begin
        y_q       <= acc_d;
        y_valid_q <= 1'b1;
      end else if (y_ready) begin
        y_valid_q <= 1'b0;
      end
    end
  end

  assign y_valid = y_valid_q;
  assign y_data  = y_q;

endmodule

// File: rtl/srm_engine_chk.sv
module srm_engine_chk #(
  parameter int YW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          b_ready,
  input logic          a_valid,
  input logic          a_ready,
  input logic          a_first,
  input logic          a_last,
  input logic          y_valid,
  input logic          y_ready,
  input logic [YW-1:0] y_data
);

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_data))); // R6

  AST_STALL_A: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |-> !a_ready); // R7

  AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && a_last) |=> y_valid); // R6

  AST_B_CLOSED_MIDROW: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && a_first && !a_last) |=> !b_ready); // R2

  AST_B_OPEN_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && a_last) |=> b_ready); // R2

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(y_valid) |-> $past(a_valid && a_ready && a_last)); // R6

endmodule

bind srm_engine srm_engine_chk #(.YW(COLS * ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .b_ready(b_ready), .a_valid(a_valid),
  .a_ready(a_ready), .a_first(a_first), .a_last(a_last),
  .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data)
);

// File: tb/sim_srm_engine.sv
`timescale 1ns/1ps
module sim_srm_engine;

  localparam int NP = 4, WM = 16, NW = 2, COLS = 8, DEPTH = NW * WM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] pass_cfg = 3'd1;
  logic b_valid = 1'b0, b_ready;
  logic [4:0] b_addr = '0;
  logic [63:0] b_data = '0;
  logic a_valid = 1'b0, a_ready, a_first = 1'b0, a_last = 1'b0;
  logic [31:0] a_val = '0;
  logic [15:0] a_idx = '0;
  logic y_valid, y_ready = 1'b1;
  logic [255:0] y_data;

  always #2 clk = ~clk;

  srm_engine u0 (.*);

  int checks = 0, errors = 0;
  string cur_req = "R3";
  bit yr_hold = 1'b0, yr_rand = 1'b0, done = 1'b0;

  // Reference state
  int bm [DEPTH][COLS];
  int macc [COLS];
  int m_y [COLS];
  bit m_yv, m_busy;
  int m_win, m_pass, m_p;
  bit fa, fy;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #1;
    if (yr_hold) y_ready = 1'b0;
    else if (yr_rand) y_ready = ($urandom % 3) != 0;
    else y_ready = 1'b1;
  end

  // Behavioural reference, advanced on every clock edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_yv = 0; m_busy = 0; m_win = 0; m_pass = 0; m_p = 1;
      for (int c = 0; c < COLS; c++) macc[c] = 0;
    end else begin
      fa = a_valid && (!m_yv || y_ready);
      fy = m_yv && y_ready;
      if (fy) m_yv = 0;
      if (fa) begin
        if (a_first) begin
          for (int c = 0; c < COLS; c++) macc[c] = 0;
          m_win = 0; m_pass = 0;
          m_p = (pass_cfg == 0) ? 1 : ((pass_cfg > 4) ? 4 : int'(pass_cfg));
        end
        for (int i = 0; i < NP; i++) begin
          int row, v;
          v = $signed(a_val[i*8 +: 8]);
          row = m_win * WM + int'(a_idx[i*4 +: 4]);
          for (int c = 0; c < COLS; c++) macc[c] += v * bm[row][c];
        end
        if (m_pass == m_p - 1) begin
          m_pass = 0;
          m_win = (m_win == NW - 1) ? 0 : m_win + 1;
        end else m_pass++;
        if (a_last) begin
          for (int c = 0; c < COLS; c++) m_y[c] = macc[c];
          m_yv = 1;
        end
      end
      if (b_valid && !m_busy)
        for (int c = 0; c < COLS; c++) bm[b_addr][c] = $signed(b_data[c*8 +: 8]);
      if (fa) m_busy = !a_last;
    end
  end

  // Port comparison in the middle of every cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(y_valid == m_yv, "R6", longint'(y_valid), longint'(m_yv), "y_valid");
      chk(a_ready == !(m_yv && !y_ready), "R7", longint'(a_ready), longint'(!(m_yv && !y_ready)), "a_ready");
      chk(b_ready == !m_busy, "R2", longint'(b_ready), longint'(!m_busy), "b_ready");
      if (m_yv)
        for (int c = 0; c < COLS; c++)
          chk($signed(y_data[c*32 +: 32]) == m_y[c], cur_req,
              longint'($signed(y_data[c*32 +: 32])), longint'(m_y[c]), "y_data lane");
    end
  end

  task automatic write_b(input int addr, input logic [63:0] d);
    @(posedge clk); #1;
    b_valid = 1'b1; b_addr = 5'(addr); b_data = d;
    forever begin @(negedge clk); if (b_ready) break; end
    @(posedge clk); #1;
    b_valid = 1'b0;
  endtask

  task automatic load_all_b();
    for (int r = 0; r < DEPTH; r++) write_b(r, {$urandom, $urandom});
  endtask

  task automatic send_beat(input bit f, input bit l, input logic [31:0] v, input logic [15:0] ix);
    @(posedge clk); #1;
    a_valid = 1'b1; a_first = f; a_last = l; a_val = v; a_idx = ix;
    forever begin @(negedge clk); if (a_ready) break; end
    @(posedge clk); #1;
    a_valid = 1'b0; a_first = 1'b0; a_last = 1'b0;
  endtask

  // kind: 0 random, 1 random pads, 2 all-zero beats in the middle, 3 extremes
  task automatic send_row(input int nbeats, input int kind);
    for (int b = 0; b < nbeats; b++) begin
      logic [31:0] v; logic [15:0] ix;
      v = $urandom; ix = 16'($urandom);
      if (kind == 1)
        for (int i = 0; i < NP; i++) if ($urandom % 2) v[i*8 +: 8] = 8'h00;
      if (kind == 2 && b > 0 && b < nbeats - 1) v = '0;
      if (kind == 3)
        for (int i = 0; i < NP; i++) v[i*8 +: 8] = ($urandom % 2) ? 8'h80 : 8'h7f;
      send_beat(b == 0, b == nbeats - 1, v, ix);
    end
  endtask

  task automatic wait_out();
    forever begin @(negedge clk); if (!m_yv) break; end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(y_valid == 1'b0, "R1", longint'(y_valid), 0, "reset y_valid");
    chk(a_ready == 1'b1, "R1", longint'(a_ready), 1, "reset a_ready");
    chk(b_ready == 1'b1, "R1", longint'(b_ready), 1, "reset b_ready");
    rst_n = 1'b1;

    cur_req = "R2"; load_all_b();

    cur_req = "R3"; pass_cfg = 3'd1;
    for (int k = 0; k < 20; k++) send_row(NW, 0);

    cur_req = "R4";
    for (int k = 0; k < 10; k++) send_row(NW, 1);
    pass_cfg = 3'd2;
    for (int k = 0; k < 6; k++) send_row(2 * NW, 2);

    cur_req = "R5"; pass_cfg = 3'd1;
    for (int k = 0; k < 8; k++) send_row(1, 0);

    cur_req = "R9";
    for (int r = 0; r < DEPTH; r += 3) write_b(r, {8{8'h80}});
    for (int k = 0; k < 6; k++) send_row(NW, 3);

    cur_req = "R10";
    wait_out();
    write_b(15, {8{8'h03}}); write_b(16, {8{8'hfd}}); write_b(31, {8{8'h11}}); write_b(0, {8{8'h01}});
    send_beat(1'b1, 1'b0, {8'd1, 8'd2, 8'd3, 8'd4}, {4'd15, 4'd0, 4'd15, 4'd0});
    send_beat(1'b0, 1'b1, {8'd5, 8'd6, 8'd7, 8'd8}, {4'd0, 4'd15, 4'd15, 4'd0});
    wait_out();
    chk($signed(y_data[31:0]) == 3*1 + 1*2 + 3*3 + 1*4 + (-3)*5 + 17*6 + 17*7 + (-3)*8, "R10",
        longint'($signed(y_data[31:0])), 3 + 2 + 9 + 4 - 15 + 102 + 119 - 24, "directed lane 0");

    cur_req = "R6"; yr_rand = 1'b1;
    for (int k = 0; k < 15; k++) send_row(NW, 0);
    yr_hold = 1'b1;
    send_row(NW, 0);
    repeat (6) @(posedge clk);
    yr_hold = 1'b0; yr_rand = 1'b0;
    wait_out();

    cur_req = "R8";
    for (int cfg = 0; cfg < 8; cfg++) begin
      int p;
      p = (cfg == 0) ? 1 : ((cfg > 4) ? 4 : cfg);
      pass_cfg = 3'(cfg);
      for (int k = 0; k < 4; k++) send_row(p * NW, 0);
      fork
        send_row(p * NW, 1);
        begin
          repeat (2) @(posedge clk);
          write_b(int'($urandom % DEPTH), {$urandom, $urandom});
        end
      join
    end

    pass_cfg = 3'd1;
    wait_out();
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule